// File: doc/BRIEF.md
# Extended Arithmetic Right-Shift Unit

This execution unit performs one operation of a legacy integer datapath: a 32-bit arithmetic right shift that also reports which bits were shifted out. It takes a source word and a shift-amount word, and uses only the low bits of the shift amount as the count. It produces four things. The first is the sign-filled shifted result. The second is the source rotated right by the same count, which the datapath writes into its auxiliary multiply-quotient register. The third is a carry flag. The fourth is a 4-bit condition field that describes the result.

The carry is raised only for a negative source from which at least one set bit was shifted out. A mask holds zeros in the top count positions and ones below them. The unit ANDs the rotated word with the complement of this mask and OR-reduces that value. A record-enable input decides whether the condition field is written. A build parameter chooses one of two forms: a purely combinational unit, or one with a single output register stage.

Top module: `xsra_unit`

## Requirements
- R1: The shift count is bits [4:0] of `shamt_word` (0 to 31). Bits [31:5] of `shamt_word` have no effect on any output.
- R2: `res_word` equals `src_word` shifted right by the count, with each vacated high bit filled with `src_word[31]`.
- R3: `rot_word` equals `src_word` rotated right by the count: bit i is `src_word[(i+count) mod 32]`. With a count of 0 it equals `src_word`.
- R4: `carry_out` is 1 exactly when `src_word[31]` is 1 and at least one of the low `count` bits of `src_word` is 1. In every other case it is 0.
- R5: When the count is 0, `carry_out` is 0 for every source word.
- R6: When `rec_en` is 1, `cond_field[3]` means the result is negative (signed), `cond_field[2]` means it is positive, and `cond_field[1]` means it is zero. Exactly one of these three bits is set.
- R7: When `rec_en` is 1, `cond_field[0]` copies `so_in`.
- R8: `cond_we` equals `rec_en`. When `rec_en` is 0, `cond_field` is 4'b0000.
- R9: With `REGISTERED`=1 (the default), every output shows the result for the inputs present at the previous rising clock edge. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| src_word | input | 32 | Word to be shifted |
| shamt_word | input | 32 | Shift-amount register value; only the low 5 bits are used |
| rec_en | input | 1 | Record flag: enables the condition-field write |
| so_in | input | 1 | Incoming summary-overflow flag |
| res_word | output | 32 | Arithmetic right-shift result |
| rot_word | output | 32 | Right-rotated source, sent to the quotient register |
| carry_out | output | 1 | Carry: negative source with set bits shifted out |
| cond_field | output | 4 | {lt, gt, eq, so} for the result |
| cond_we | output | 1 | Condition-field write strobe |

## Verification
The assertions check several properties on every cycle. They compare the low bits of the result, inside the mask, with the rotated word. They check that the high bits of the result, outside the mask, all equal the sign. They check that carry never appears for a non-negative source or a zero count, that the compare bits are one-hot, and that the output register follows its input with one cycle of delay. Only the bench's scenarios can show that carry rises for the exact shifted-out patterns, such as a set bit just below the count boundary compared with one just above it. The same holds for whether the upper shift-amount bits are ignored, and for the encoded value of the condition field against an independent bit-loop model.

// File: rtl/xsra_pkg.sv
package xsra_pkg;
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;
endpackage

// File: rtl/xsra_rotmask.sv
module xsra_rotmask #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  src,
  input  logic [SW-1:0] cnt,
  output logic [W-1:0]  rot,
  output logic [W-1:0]  mask
);
  function automatic logic [W-1:0] rotr_f(input logic [W-1:0] v, input logic [SW-1:0] n);
    logic [2*W-1:0] dbl;
    dbl = {v, v} >> n;
    return dbl[W-1:0];
  endfunction

  function automatic logic [W-1:0] mask_f(input logic [SW-1:0] n);
    return {W{1'b1}} >> n;
  endfunction

  assign rot  = rotr_f(src, cnt);
  assign mask = mask_f(cnt);
endmodule

// File: rtl/xsra_shifter.sv
module xsra_shifter #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  src,
  input  logic [SW-1:0] cnt,
  output logic [W-1:0]  res
);
  logic [W-1:0] stage [SW+1];
  assign stage[0] = src;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = cnt[k]
      ? {{STEP{stage[k][W-1]}}, stage[k][W-1:STEP]}
      : stage[k];
  end

  assign res = stage[SW];
endmodule

// File: rtl/xsra_flags.sv
module xsra_flags
  import xsra_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] rot,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] res,
  input  logic         so_in,
  input  logic         rec_en,
  output logic         spill,
  output logic         carry,
  output cond_t        cond,
  output logic         cond_we
);
  assign spill   = |(rot & ~mask);
  assign carry   = src[W-1] & spill;
  assign cond_we = rec_en;

  always_comb begin
    cond = '0;
    if (rec_en) begin
      cond.lt = res[W-1];
      cond.gt = !res[W-1] && (res != '0);
      cond.eq = (res == '0);
      cond.so = so_in;
    end
  end
endmodule

// File: rtl/xsra_unit.sv
module xsra_unit
  import xsra_pkg::*;
#(
  parameter int W          = 32,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_word,
  input  logic [W-1:0] shamt_word,
  input  logic         rec_en,
  input  logic         so_in,
  output logic [W-1:0] res_word,
  output logic [W-1:0] rot_word,
  output logic         carry_out,
  output logic [3:0]   cond_field,
  output logic         cond_we
);
  localparam int SW = $clog2(W);

  logic [SW-1:0] cnt;
  logic [W-1:0]  rot_c, mask_c, res_c;
  logic          spill_c, carry_c, we_c;
  cond_t         cond_c;

  assign cnt = shamt_word[SW-1:0];

  xsra_rotmask #(.W(W), .SW(SW)) u_rot (
    .src(src_word), .cnt(cnt), .rot(rot_c), .mask(mask_c)
  );

  xsra_shifter #(.W(W), .SW(SW)) u_shf (
    .src(src_word), .cnt(cnt), .res(res_c)
  );

  xsra_flags #(.W(W)) u_flg (
    .src(src_word), .rot(rot_c), .mask(mask_c), .res(res_c),
    .so_in(so_in), .rec_en(rec_en), .spill(spill_c), .carry(carry_c),
    .cond(cond_c), .cond_we(we_c)
  );

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_word   <= '0;
        rot_word   <= '0;
        carry_out  <= 1'b0;
        cond_field <= '0;
        cond_we    <= 1'b0;
      end else begin
        res_word   <= res_c;
        rot_word   <= rot_c;
        carry_out  <= carry_c;
        cond_field <= cond_c;
        cond_we    <= we_c;
      end
    end

    AST_PIPE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (res_word == $past(res_c) && carry_out == $past(carry_c))); // R9
  end else begin : g_comb
    assign res_word   = res_c;
    assign rot_word   = rot_c;
    assign carry_out  = carry_c;
    assign cond_field = cond_c;
    assign cond_we    = we_c;
  end

  AST_LOW_MATCHES_ROT: assert property (@(posedge clk) disable iff (!rst_n)
    ((res_c & mask_c) == (rot_c & mask_c))); // R2
  AST_HIGH_IS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ((res_c & ~mask_c) == (src_word[W-1] ? ~mask_c : '0))); // R2
  AST_ZERO_CNT_ROT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (rot_c == src_word)); // R3
  AST_CARRY_NEEDS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    carry_c |-> (src_word[W-1] && spill_c)); // R4
  AST_ZERO_CNT_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !carry_c); // R5
  AST_COND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rec_en |-> $onehot({cond_c.lt, cond_c.gt, cond_c.eq})); // R6
  AST_COND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_en |-> (cond_c == '0 && !we_c)); // R8
endmodule

// File: tb/sim_xsra_unit.sv
module sim_xsra_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_word = '0, shamt_word = '0;
  logic        rec_en = 1'b0, so_in = 1'b0;
  logic [31:0] res_word, rot_word;
  logic        carry_out, cond_we;
  logic [3:0]  cond_field;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  xsra_unit u0 (
    .clk(clk), .rst_n(rst_n), .src_word(src_word), .shamt_word(shamt_word),
    .rec_en(rec_en), .so_in(so_in), .res_word(res_word), .rot_word(rot_word),
    .carry_out(carry_out), .cond_field(cond_field), .cond_we(cond_we)
  );

  // {src, shamt, rec, so, expected carry}
  localparam logic [66:0] VEC [12] = '{
    {32'h8000_0001, 32'h0000_0001, 1'b1, 1'b0, 1'b1},
    {32'h8000_0000, 32'h0000_001F, 1'b1, 1'b1, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 1'b0},
    {32'h7FFF_FFFF, 32'h0000_001F, 1'b1, 1'b0, 1'b0},
    {32'hF000_0010, 32'h0000_0004, 1'b0, 1'b1, 1'b0},
    {32'hF000_0010, 32'h0000_0005, 1'b1, 1'b0, 1'b1},
    {32'h1234_5678, 32'hFFFF_FFE3, 1'b1, 1'b1, 1'b0},
    {32'h8765_4321, 32'h0000_0020, 1'b1, 1'b0, 1'b0},
    {32'h8000_0003, 32'h0000_0021, 1'b1, 1'b0, 1'b1},
    {32'h0000_0000, 32'h0000_0007, 1'b1, 1'b0, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_001F, 1'b1, 1'b1, 1'b1},
    {32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0, 1'b0}
  };

  function automatic logic [31:0] m_res(input logic [31:0] s, input int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? s[i+n] : s[31];
    return r;
  endfunction

  function automatic logic [31:0] m_rot(input logic [31:0] s, input int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = s[(i + n) % 32];
    return r;
  endfunction

  function automatic logic m_carry(input logic [31:0] s, input int n);
    logic any = 1'b0;
    for (int j = 0; j < n; j++) if (s[j]) any = 1'b1;
    return s[31] & any;
  endfunction

  function automatic logic [3:0] m_cond(input logic [31:0] r, input logic rec, input logic so);
    if (!rec) return 4'b0000;
    if ($signed(r) < 0) return {3'b100, so};
    if ($signed(r) > 0) return {3'b010, so};
    return {3'b001, so};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_and_check(input logic [31:0] s, input logic [31:0] sh,
                                 input logic rec, input logic so, input bit use_ec, input logic ec);
    int n;
    logic [31:0] er;
    @(negedge clk);
    src_word = s; shamt_word = sh; rec_en = rec; so_in = so;
    n = int'(sh[4:0]);
    er = m_res(s, n);
    @(posedge clk); #1;
    chk("R1/R2 result", res_word, er);
    chk("R3 rotate", rot_word, m_rot(s, n));
    chk("R4 carry", {31'b0, carry_out}, {31'b0, m_carry(s, n)});
    if (use_ec) chk("R4 carry table", {31'b0, carry_out}, {31'b0, ec});
    if (n == 0) chk("R5 zero count carry", {31'b0, carry_out}, 32'd0);
    chk("R6/R7 cond", {28'b0, cond_field}, {28'b0, m_cond(er, rec, so)});
    chk("R8 cond_we", {31'b0, cond_we}, {31'b0, rec});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9: reset clears outputs even with live inputs
    src_word = 32'hFFFF_FFFF; shamt_word = 32'd3; rec_en = 1'b1; so_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset res", res_word, 32'd0);
    chk("R9 reset rot", rot_word, 32'd0);
    chk("R9 reset flags", {26'b0, carry_out, cond_field, cond_we}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    foreach (VEC[i]) begin
      apply_and_check(VEC[i][66:35], VEC[i][34:3], VEC[i][2], VEC[i][1], 1'b1, VEC[i][0]);
    end

    // R1: upper shamt bits ignored, same low bits give identical outputs
    apply_and_check(32'hC3A5_0F0F, 32'h0000_0009, 1'b1, 1'b0, 1'b0, 1'b0);
    apply_and_check(32'hC3A5_0F0F, 32'hABCD_EF09, 1'b1, 1'b0, 1'b0, 1'b0);

    // R4: set bit just inside vs just outside shifted-out window
    apply_and_check(32'h8000_0100, 32'd9, 1'b1, 1'b0, 1'b1, 1'b1);
    apply_and_check(32'h8000_0100, 32'd8, 1'b1, 1'b0, 1'b1, 1'b0);

    // R9: one-cycle latency, output reflects previous edge's inputs
    @(negedge clk);
    src_word = 32'h0000_0040; shamt_word = 32'd6; rec_en = 1'b1; so_in = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    src_word = 32'h8000_0000; shamt_word = 32'd1;
    #1;
    chk("R9 hold until edge", res_word, 32'd1);
    @(posedge clk); #1;
    chk("R9 next edge", res_word, 32'hC000_0000);

    for (int k = 0; k < 300; k++) begin
      logic [31:0] s, sh;
      s  = $urandom();
      sh = $urandom();
      if (k % 3 == 0) sh[4:0] = 5'd0;
      if (k % 5 == 0) sh[4:0] = 5'd31;
      if (k % 7 == 0) sh[4:0] = 5'd1;
      if (k % 2 == 0) s[31] = 1'b1;
      apply_and_check(s, sh, 1'($urandom()), 1'($urandom()), 1'b0, 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule